// File: doc/BRIEF.md
# Doorbell-Driven Command Queue Engine

This block is the device side of one submission/completion queue pair held in host memory. The host writes command entries of 64 bytes into a circular submission ring and announces them by writing the new submission tail index to a doorbell. The engine reads pending entries strictly in ring order. Each entry arrives as sixteen 32-bit reads over a simple memory port that stands in for DMA, and the engine passes its words to a small command-processing stub.

For every command the engine writes a completion entry of 16 bytes into a circular completion ring and then pulses an interrupt request. The host reads completions, recognises new ones by a phase bit that flips on every lap of the ring, and returns the slots by writing the new completion head index to a second doorbell. While the completion ring is full the engine holds the finished command and waits for the host to free a slot. A doorbell value outside the ring is discarded and sets a sticky error flag.

Top module: `qe_engine`

## Requirements
- R1: After reset, `irq`, `mem_req` and `db_err` are low and no memory access takes place until a submission doorbell announces work.
- R2: Each pending submission entry at index i is read as exactly 16 consecutive 32-bit reads at byte addresses SQ_BASE + 64*i + 4*b for b = 0..15. Entries are read from the device head up to, but not including, the written tail, one entry at a time and in ring order.
- R3: The completion for a command is four 32-bit writes at CQ_BASE + 16*s + 4*w (s = completion slot, w = 0..3). Word 0 is the XOR of the 16 command words. Word 1 is zero. Word 2 holds the submission head index after this command was consumed, in bits 15:0. Word 3 holds the command identifier (bits 31:16 of command word 0) in bits 15:0 and the phase in bit 16, with all other bits zero.
- R4: Each posted completion produces exactly one `irq` pulse of one cycle, high in the cycle right after the clock edge that writes completion word 3.
- R5: Both ring indices wrap modulo QDEPTH: the index that follows QDEPTH-1 is 0.
- R6: No completion is written while the completion ring is full, that is, while advancing the completion tail would make it equal to the completion head. Posting resumes once a completion head doorbell frees a slot.
- R7: The phase written into completions is 1 during the first lap of the completion ring and toggles each time the completion tail wraps to 0.
- R8: A doorbell write with a value at or above QDEPTH changes neither ring index and sets `db_err`, which stays set until reset.
- R9: A submission tail doorbell equal to the current device head starts no fetch and produces no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| db_wr | input | 1 | Doorbell write strobe |
| db_sel | input | 1 | Doorbell select: 0 submission tail, 1 completion head |
| db_data | input | 32 | Index value written to the selected doorbell |
| mem_req | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| irq | output | 1 | Interrupt request pulse after a completion is posted |
| db_err | output | 1 | Sticky flag for an out-of-range doorbell value |

## Verification
The hardest state to reach from the ports is a fully occupied completion ring with a command already fetched and waiting. The stimulus gets there by submitting seven commands without consuming any completion. It then submits an eighth and watches that the entry is read but nothing is written and no interrupt appears for a long window. The head doorbell then releases the ring. The table-driven batches before this point carry both rings across several wraps, so the phase flip and the head value reported in word 2 are checked on both sides of the wrap.

// File: rtl/qe_pkg.sv
package qe_pkg;

    localparam int          DATA_W   = 32;
    localparam logic [4:0]  SQ_BEATS = 5'd16;   // 64-byte entry over 32-bit port
    localparam logic [1:0]  CQ_LAST  = 2'd3;    // 16-byte completion, 4 beats

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_POST,
        ST_IRQ
    } qe_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic [15:0]       cid;
    } qe_cpl_t;

endpackage

// File: rtl/qe_ring_ptrs.sv
module qe_ring_ptrs #(
    parameter int QDEPTH = 8,
    parameter int IDX_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             db_wr,
    input  logic             db_sel,
    input  logic [31:0]      db_data,
    input  logic             sq_adv,
    input  logic             cq_adv,
    output logic [IDX_W-1:0] sq_head,
    output logic             sq_pending,
    output logic [IDX_W-1:0] cq_tail,
    output logic             cq_full,
    output logic             phase,
    output logic             db_err
);

    logic [IDX_W-1:0] sq_tail;
    logic [IDX_W-1:0] cq_head;
    logic             db_ok;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
        return (32'(i) == QDEPTH - 1) ? '0 : i + 1'b1;
    endfunction

    assign db_ok      = (db_data < 32'(QDEPTH));
    assign sq_pending = (sq_head != sq_tail);
    assign cq_full    = (step(cq_tail) == cq_head);

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_head <= '0;
            sq_tail <= '0;
            cq_head <= '0;
            cq_tail <= '0;
            phase   <= 1'b1;
            db_err  <= 1'b0;
        end else begin
            if (db_wr) begin
                if (!db_ok)      db_err  <= 1'b1;
                else if (db_sel) cq_head <= db_data[IDX_W-1:0];
                else             sq_tail <= db_data[IDX_W-1:0];
            end
            if (sq_adv) sq_head <= step(sq_head);
            if (cq_adv) begin
                cq_tail <= step(cq_tail);
                if (32'(cq_tail) == QDEPTH - 1) phase <= ~phase;
            end
        end
    end

    assert_sq_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (sq_adv && 32'(sq_head) == QDEPTH - 1) |=> (sq_head == '0));

    assert_phase_flip_R7: assert property (@(posedge clk) disable iff (rst)
        (cq_adv && 32'(cq_tail) == QDEPTH - 1) |=> (phase != $past(phase)));

    assert_bad_db_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (db_wr && !db_ok) |=> (db_err && $stable(sq_tail) && $stable(cq_head)));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        $past(db_err) |-> db_err);

endmodule

// File: rtl/qe_cmd_stub.sv
module qe_cmd_stub
    import qe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              word_vld,
    input  logic              word_first,
    input  logic [DATA_W-1:0] word,
    output qe_cpl_t           cpl
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cpl <= '0;
        end else if (word_vld) begin
            cpl.result <= cpl.result ^ word;
            if (word_first) cpl.cid <= word[31:16];
        end
    end

endmodule

// File: rtl/qe_engine.sv
module qe_engine
    import qe_pkg::*;
#(
    parameter int          QDEPTH  = 8,
    parameter logic [31:0] SQ_BASE = 32'h0000_1000,
    parameter logic [31:0] CQ_BASE = 32'h0000_4000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        db_wr,
    input  logic        db_sel,
    input  logic [31:0] db_data,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        irq,
    output logic        db_err
);

    localparam int IDX_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

    qe_state_e        state_q;
    logic [4:0]       issue_q;
    logic [4:0]       cap_q;
    logic             rd_pend_q;
    logic [1:0]       beat_q;

    logic [IDX_W-1:0] sq_head;
    logic [IDX_W-1:0] cq_tail;
    logic             sq_pending;
    logic             cq_full;
    logic             phase;
    logic             sq_adv;
    logic             cq_adv;
    logic             last_cap;
    qe_cpl_t          cpl;

    qe_ring_ptrs #(.QDEPTH(QDEPTH), .IDX_W(IDX_W)) u_ptrs (
        .clk        (clk),
        .rst        (rst),
        .db_wr      (db_wr),
        .db_sel     (db_sel),
        .db_data    (db_data),
        .sq_adv     (sq_adv),
        .cq_adv     (cq_adv),
        .sq_head    (sq_head),
        .sq_pending (sq_pending),
        .cq_tail    (cq_tail),
        .cq_full    (cq_full),
        .phase      (phase),
        .db_err     (db_err)
    );

    qe_cmd_stub u_stub (
        .clk        (clk),
        .rst        (rst),
        .clr        (state_q == ST_IDLE),
        .word_vld   (rd_pend_q),
        .word_first (cap_q == 5'd0),
        .word       (mem_rdata),
        .cpl        (cpl)
    );

    assign last_cap = rd_pend_q && (cap_q == SQ_BEATS - 5'd1);
    assign irq      = (state_q == ST_IRQ);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        sq_adv    = 1'b0;
        cq_adv    = 1'b0;
        case (state_q)
            ST_FETCH: begin
                if (issue_q < SQ_BEATS) begin
                    mem_req  = 1'b1;
                    mem_addr = SQ_BASE + (32'(sq_head) << 6) + (32'(issue_q) << 2);
                end
                sq_adv = last_cap;
            end
            ST_POST: begin
                mem_req  = (beat_q != 2'd0) || !cq_full;
                mem_we   = 1'b1;
                mem_addr = CQ_BASE + (32'(cq_tail) << 4) + (32'(beat_q) << 2);
                case (beat_q)
                    2'd0:    mem_wdata = cpl.result;
                    2'd1:    mem_wdata = '0;
                    2'd2:    mem_wdata = 32'(sq_head);
                    default: mem_wdata = {15'd0, phase, cpl.cid};
                endcase
                cq_adv = mem_req && (beat_q == CQ_LAST);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            issue_q   <= '0;
            cap_q     <= '0;
            rd_pend_q <= 1'b0;
            beat_q    <= '0;
        end else begin
            rd_pend_q <= (state_q == ST_FETCH) && (issue_q < SQ_BEATS);
            case (state_q)
                ST_IDLE: begin
                    issue_q <= '0;
                    cap_q   <= '0;
                    beat_q  <= '0;
                    if (sq_pending) state_q <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (issue_q < SQ_BEATS) issue_q <= issue_q + 5'd1;
                    if (rd_pend_q)          cap_q   <= cap_q + 5'd1;
                    if (last_cap)           state_q <= ST_POST;
                end
                ST_POST: begin
                    if (mem_req) begin
                        beat_q <= beat_q + 2'd1;
                        if (beat_q == CQ_LAST) state_q <= ST_IRQ;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_irq_after_post_R4: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(mem_req && mem_we && beat_q == CQ_LAST));

    assert_no_post_when_full_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && beat_q == 2'd0) |-> !cq_full);

    assert_read_only_pending_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> sq_pending);

    assert_irq_single_R4: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

endmodule

// File: tb/qe_engine_tb.sv
`timescale 1ns/1ps
module qe_engine_tb;

    localparam int          QD   = 8;
    localparam logic [31:0] SQB  = 32'h0000_1000;
    localparam logic [31:0] CQB  = 32'h0000_4000;

    // {command count, seed}
    localparam logic [15:0] VEC [0:5] = '{16'h0111, 16'h0322, 16'h0533,
                                           16'h0244, 16'h0655, 16'h0466};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        db_wr = 1'b0;
    logic        db_sel = 1'b0;
    logic [31:0] db_data = '0;
    logic        mem_req, mem_we, irq, db_err;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    always #2 clk = ~clk;

    qe_engine #(.QDEPTH(QD), .SQ_BASE(SQB), .CQ_BASE(CQB)) u_dut (
        .clk(clk), .rst(rst), .db_wr(db_wr), .db_sel(db_sel), .db_data(db_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq), .db_err(db_err)
    );

    logic [31:0] sq_mem [0:QD*16-1];
    logic [31:0] cq_mem [0:QD*4-1];

    int tests = 0, fails = 0;
    int cyc = 0, rd_total = 0, wr_total = 0, irq_cnt = 0;
    int rd_bad = 0, irq_bad = 0, last_wr3 = -10;
    int exp_slot = 0, exp_beat = 0;

    // host-side bookkeeping
    int hsq = 0, hcq = 0, hph = 1, nsub = 0, ncon = 0;
    logic [31:0] log_res [0:63];
    logic [15:0] log_cid [0:63];
    int          log_sqh [0:63];

    always @(posedge clk) begin
        cyc++;
        if (mem_req && !mem_we) begin
            mem_rdata <= sq_mem[7'((mem_addr - SQB) >> 2)];
            if (mem_addr != SQB + 32'(exp_slot * 64 + exp_beat * 4)) rd_bad++;
            rd_total++;
            exp_beat++;
            if (exp_beat == 16) begin exp_beat = 0; exp_slot = (exp_slot + 1) % QD; end
        end
        if (mem_req && mem_we) begin
            cq_mem[5'((mem_addr - CQB) >> 2)] <= mem_wdata;
            wr_total++;
            if (mem_addr[3:2] == 2'd3) last_wr3 = cyc;
        end
        if (irq) begin
            irq_cnt++;
            if (cyc != last_wr3 + 1) irq_bad++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ring(input logic sel, input int val);
        @(negedge clk);
        db_wr = 1'b1; db_sel = sel; db_data = 32'(val);
        @(negedge clk);
        db_wr = 1'b0;
    endtask

    task automatic submit(input int n, input logic [7:0] seed);
        for (int k = 0; k < n; k++) begin
            logic [31:0] acc = '0;
            for (int b = 0; b < 16; b++) begin
                logic [31:0] w = {8'(seed), 8'(nsub), 8'(b), 8'(b * 7 + nsub)};
                sq_mem[hsq * 16 + b] = w;
                acc ^= w;
            end
            log_res[nsub] = acc;
            log_cid[nsub] = {8'(seed), 8'(nsub)};
            hsq = (hsq + 1) % QD;
            log_sqh[nsub] = hsq;
            nsub++;
        end
        ring(1'b0, hsq);
    endtask

    task automatic wait_irq(input int target);
        int t = 0;
        while (irq_cnt < target && t < 4000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic consume(input int n);
        for (int k = 0; k < n; k++) begin
            check("R3 word0 result", cq_mem[hcq * 4 + 0], log_res[ncon]);
            check("R3 word1 zero",   cq_mem[hcq * 4 + 1], 32'd0);
            check("R3/R5 word2 sq head", cq_mem[hcq * 4 + 2], 32'(log_sqh[ncon]));
            check("R3/R7 word3 phase+cid", cq_mem[hcq * 4 + 3],
                  {15'd0, 1'(hph), log_cid[ncon]});
            hcq = (hcq + 1) % QD;
            if (hcq == 0) hph ^= 1;
            ncon++;
        end
        ring(1'b1, hcq);
    endtask

    initial begin
        #(4ns * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int r0, i0, w0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 irq", 32'(irq), 0);
        check("R1 mem_req", 32'(mem_req), 0);
        check("R1 db_err", 32'(db_err), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        check("R1 idle no access", 32'(rd_total + wr_total), 0);

        // table walk: batches crossing ring wraps (R2 R3 R5 R7)
        for (int v = 0; v < 6; v++) begin
            submit(int'(VEC[v][15:8]), VEC[v][7:0]);
            wait_irq(nsub);
            check("R4 irq count per batch", 32'(irq_cnt), 32'(nsub));
            consume(int'(VEC[v][15:8]));
        end

        // R9: tail doorbell equal to head
        r0 = rd_total; i0 = irq_cnt;
        ring(1'b0, hsq);
        repeat (40) @(negedge clk);
        check("R9 no fetch on empty", 32'(rd_total), 32'(r0));
        check("R9 no irq on empty", 32'(irq_cnt), 32'(i0));

        // R8: out-of-range doorbells
        ring(1'b0, QD);
        check("R8 err set", 32'(db_err), 1);
        repeat (40) @(negedge clk);
        check("R8 sq tail unchanged", 32'(rd_total), 32'(r0));
        ring(1'b1, QD + 4);
        check("R8 err sticky", 32'(db_err), 1);
        submit(1, 8'h77);
        wait_irq(nsub);
        check("R8 bad cq head ignored", 32'(irq_cnt), 32'(nsub));
        consume(1);

        // R6: completion ring full stall
        submit(7, 8'h88);
        wait_irq(nsub);
        check("R6 seven posted", 32'(irq_cnt), 32'(nsub));
        r0 = rd_total; i0 = irq_cnt; w0 = wr_total;
        submit(1, 8'h99);
        repeat (120) @(negedge clk);
        check("R6 stalled entry fetched", 32'(rd_total), 32'(r0 + 16));
        check("R6 no write when full", 32'(wr_total), 32'(w0));
        check("R6 no irq when full", 32'(irq_cnt), 32'(i0));
        consume(7);
        wait_irq(nsub);
        check("R6 resumes after head", 32'(irq_cnt), 32'(nsub));
        consume(1);

        repeat (10) @(negedge clk);
        check("R2 fetch address order", 32'(rd_bad), 0);
        check("R2 reads per entry", 32'(rd_total), 32'(nsub * 16));
        check("R4 irq timing", 32'(irq_bad), 0);
        check("R4 irq total", 32'(irq_cnt), 32'(ncon));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule